// File: doc/BRIEF.md
# JTAG Instruction Register with Opcode Decoder

This block holds the instruction of a test access port. It has a five-bit serial stage, clocked on the rising test-clock edge, and a five-bit latched stage, clocked on the falling edge. An external TAP state machine supplies four strobes: capture, shift, update and logic-reset. While the state machine sits in the capture state, the serial stage loads a fixed marker value. While it sits in the shift state, the serial stage moves new opcode bits in from the test data input. The marker comes out on the serial output, least significant bit first.

A new opcode takes effect only when the update strobe copies the serial stage into the latched stage. That copy ends whatever the previous instruction had selected. Two events return the latched stage to the identification opcode: the asynchronous test reset, and the logic-reset strobe. A combinational decoder turns the latched opcode into three outputs: a one-hot select for the test data registers, a flag that hands the device pins to the test logic, and a flag that puts all outputs in high impedance.

Top module: `jtag_ir_unit`

## Requirements
- R1: The register is 5 bits wide and has a serial stage and a latched stage. With trst_n low, ir_active is 5'b11110, the serial stage holds 5'b00001 and ir_so is 0.
- R2: On a rising tck edge with shift_ir high and capture_ir low, tdi enters bit 4 of the serial stage, and every other bit moves one place toward bit 0.
- R3: On a rising tck edge with capture_ir high, the serial stage loads 5'b00001. Capture wins when shift_ir is also high. A following shift therefore presents 1,0,0,0,0 on ir_so.
- R4: ir_so is a register. It takes bit 0 of the serial stage on each falling tck edge.
- R5: On a falling tck edge with update_ir high, the latched stage loads the serial stage. At every other time the latched stage holds its value, including all of the shift cycles.
- R6: trst_n low forces ir_active to 5'b11110 at once, without any tck edge.
- R7: On a falling tck edge with tlr high, ir_active becomes 5'b11110. This takes priority over update_ir.
- R8: dr_sel is one-hot, with these bit positions: 0 boundary, 1 bypass, 2 idcode, 3 debug receive, 4 debug transmit, 5 debug control/status, 6 instruction-cache load.
- R9: These opcodes select a register. 00000 and 00001 select boundary. 00010 selects debug receive. 10000 selects debug transmit. 01001 selects control/status. 00111 selects cache load. 11110 selects idcode. 00100, 01000 and 11111 select bypass.
- R10: pin_ctl is 1 for opcodes 00000, 00100 and 01000. pin_hiz is 1 only for 01000.
- R11: Every opcode that R9 does not list selects bypass, with pin_ctl and pin_hiz at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tdi | input | 1 | Serial test data in |
| capture_ir | input | 1 | TAP in the instruction-capture state |
| shift_ir | input | 1 | TAP in the instruction-shift state |
| update_ir | input | 1 | TAP in the instruction-update state |
| tlr | input | 1 | TAP in the test-logic-reset state |
| ir_so | output | 1 | Registered serial output toward the test data output |
| ir_active | output | 5 | Latched, active opcode |
| dr_sel | output | 7 | One-hot test data register select |
| pin_ctl | output | 1 | Test logic controls the device pins |
| pin_hiz | output | 1 | All outputs forced to high impedance |

## Verification
The serial stage moves on the rising edge, and ir_so follows it half a period later, at the falling edge. The latched stage, and through combinational decode dr_sel and the flags, change at the falling edge of the cycle in which update or logic-reset is high. The test reset acts at once. The bench changes inputs 2 ns after a rising edge. It reads ir_so 2 ns after the next falling edge, and reads ir_active both 3 ns before and 2 ns after the update edge, so that both the hold and the load are observed. Test reset is checked 1 ns after trst_n falls, well clear of any tck edge.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;
  localparam int IR_W  = 5;
  localparam int SEL_W = 7;

  localparam int SEL_BSR   = 0;
  localparam int SEL_BYP   = 1;
  localparam int SEL_ID    = 2;
  localparam int SEL_DRX   = 3;
  localparam int SEL_DTX   = 4;
  localparam int SEL_DCS   = 5;
  localparam int SEL_CACHE = 6;

  localparam logic [IR_W-1:0] OP_EXTEST = 5'b00000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 5'b00001;
  localparam logic [IR_W-1:0] OP_DRX    = 5'b00010;
  localparam logic [IR_W-1:0] OP_CLAMP  = 5'b00100;
  localparam logic [IR_W-1:0] OP_CACHE  = 5'b00111;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 5'b01000;
  localparam logic [IR_W-1:0] OP_DCS    = 5'b01001;
  localparam logic [IR_W-1:0] OP_DTX    = 5'b10000;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'b11110;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'b11111;

  localparam logic [IR_W-1:0] CAP_PAT = 5'b00001;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             pin_ctl;
    logic             pin_hiz;
  } ir_dec_t;

  // index of the data register chosen by an opcode
  function automatic int unsigned sel_index(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLE: sel_index = SEL_BSR;
      OP_DRX:               sel_index = SEL_DRX;
      OP_DTX:               sel_index = SEL_DTX;
      OP_DCS:               sel_index = SEL_DCS;
      OP_CACHE:             sel_index = SEL_CACHE;
      OP_IDCODE:            sel_index = SEL_ID;
      default:              sel_index = SEL_BYP;
    endcase
  endfunction

  function automatic logic takes_pins(input logic [IR_W-1:0] op);
    takes_pins = (op == OP_EXTEST) || (op == OP_CLAMP) || (op == OP_HIGHZ);
  endfunction

  function automatic logic floats_pins(input logic [IR_W-1:0] op);
    floats_pins = (op == OP_HIGHZ);
  endfunction
endpackage

// File: rtl/ir_shift_stage.sv
module ir_shift_stage #(
  parameter int             W   = 5,
  parameter logic [W-1:0]   CAP = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tdi,
  input  logic         capture,
  input  logic         shift,
  output logic [W-1:0] sr,
  output logic         so
);
  logic [W-1:0] sr_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      sr_q <= CAP;
    else if (capture) sr_q <= CAP;
    else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) so <= 1'b0;
    else         so <= sr_q[0];
  end

  assign sr = sr_q;
endmodule

// File: rtl/ir_hold_stage.sv
module ir_hold_stage #(
  parameter int           W    = 5,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         update,
  input  logic         tlr,
  input  logic [W-1:0] sr,
  output logic [W-1:0] op
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)     op <= INIT;
    else if (tlr)    op <= INIT;
    else if (update) op <= sr;
  end
endmodule

// File: rtl/ir_decoder.sv
module ir_decoder
  import jtag_ir_pkg::*;
(
  input  logic [IR_W-1:0] op,
  output ir_dec_t         dec
);
  int unsigned idx;
  assign idx = sel_index(op);

  for (genvar g = 0; g < SEL_W; g++) begin : g_sel
    assign dec.sel[g] = (idx == g);
  end

  assign dec.pin_ctl = takes_pins(op);
  assign dec.pin_hiz = floats_pins(op);
endmodule

// File: rtl/jtag_ir_unit.sv
module jtag_ir_unit
  import jtag_ir_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  logic             capture_ir,
  input  logic             shift_ir,
  input  logic             update_ir,
  input  logic             tlr,
  output logic             ir_so,
  output logic [IR_W-1:0]  ir_active,
  output logic [SEL_W-1:0] dr_sel,
  output logic             pin_ctl,
  output logic             pin_hiz
);
  logic [IR_W-1:0] shift_val;
  ir_dec_t         dec;

  ir_shift_stage #(.W(IR_W), .CAP(CAP_PAT)) u_shift (
    .tck(tck), .trst_n(trst_n), .tdi(tdi),
    .capture(capture_ir), .shift(shift_ir),
    .sr(shift_val), .so(ir_so)
  );

  ir_hold_stage #(.W(IR_W), .INIT(OP_IDCODE)) u_hold (
    .tck(tck), .trst_n(trst_n), .update(update_ir), .tlr(tlr),
    .sr(shift_val), .op(ir_active)
  );

  ir_decoder u_dec (.op(ir_active), .dec(dec));

  assign dr_sel  = dec.sel;
  assign pin_ctl = dec.pin_ctl;
  assign pin_hiz = dec.pin_hiz;
endmodule

// File: rtl/jtag_ir_unit_chk.sv
module jtag_ir_unit_chk
  import jtag_ir_pkg::*;
(
  input logic             tck,
  input logic             trst_n,
  input logic             tdi,
  input logic             capture_ir,
  input logic             shift_ir,
  input logic             update_ir,
  input logic             tlr,
  input logic             ir_so,
  input logic [IR_W-1:0]  ir_active,
  input logic [SEL_W-1:0] dr_sel,
  input logic             pin_ctl,
  input logic             pin_hiz,
  input logic [IR_W-1:0]  shift_val
);
  // R3
  capture_pattern_chk: assert property (@(posedge tck) disable iff (!trst_n)
    capture_ir |=> shift_val == CAP_PAT);

  // R2
  shift_move_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (shift_ir && !capture_ir) |=>
      (shift_val == {$past(tdi), $past(shift_val[IR_W-1:1])}));

  // R4
  so_follow_chk: assert property (@(negedge tck) disable iff (!trst_n)
    1'b1 |=> ir_so == $past(shift_val[0]));

  // R5
  hold_stable_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (!update_ir && !tlr) |=> $stable(ir_active));

  // R5
  update_load_chk: assert property (@(negedge tck) disable iff (!trst_n)
    (update_ir && !tlr) |=> ir_active == $past(shift_val));

  // R7
  tlr_idcode_chk: assert property (@(negedge tck) disable iff (!trst_n)
    tlr |=> ir_active == OP_IDCODE);

  // R8
  sel_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $countones(dr_sel) == 1);

  // R10
  hiz_implies_pins_chk: assert property (@(posedge tck) disable iff (!trst_n)
    pin_hiz |-> pin_ctl);
endmodule

bind jtag_ir_unit jtag_ir_unit_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_ir(capture_ir),
  .shift_ir(shift_ir), .update_ir(update_ir), .tlr(tlr), .ir_so(ir_so),
  .ir_active(ir_active), .dr_sel(dr_sel), .pin_ctl(pin_ctl),
  .pin_hiz(pin_hiz), .shift_val(shift_val)
);

// File: tb/test_jtag_ir_unit.sv
module test_jtag_ir_unit;
  logic tck = 1'b0;
  logic trst_n = 1'b1;
  logic tdi = 1'b0, capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0, tlr = 1'b0;
  logic       ir_so;
  logic [4:0] ir_active;
  logic [6:0] dr_sel;
  logic       pin_ctl, pin_hiz;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [4:0] exp_act;

  // expected {dr_sel[6:0], pin_ctl, pin_hiz} per opcode, per R8..R11
  localparam logic [8:0] EXP [0:31] = '{
    9'b000000110, 9'b000000100, 9'b000100000, 9'b000001000,
    9'b000001010, 9'b000001000, 9'b000001000, 9'b100000000,
    9'b000001011, 9'b010000000, 9'b000001000, 9'b000001000,
    9'b000001000, 9'b000001000, 9'b000001000, 9'b000001000,
    9'b001000000, 9'b000001000, 9'b000001000, 9'b000001000,
    9'b000001000, 9'b000001000, 9'b000001000, 9'b000001000,
    9'b000001000, 9'b000001000, 9'b000001000, 9'b000001000,
    9'b000001000, 9'b000001000, 9'b000010000, 9'b000001000
  };
  localparam logic [4:0] TDO_PAT = 5'b00001;

  jtag_ir_unit i_jtag_ir_unit (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_ir(capture_ir),
    .shift_ir(shift_ir), .update_ir(update_ir), .tlr(tlr), .ir_so(ir_so),
    .ir_active(ir_active), .dr_sel(dr_sel), .pin_ctl(pin_ctl), .pin_hiz(pin_hiz)
  );

  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic load_ir(input logic [4:0] op);
    @(posedge tck); #2 capture_ir = 1'b1; shift_ir = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge tck); #2 capture_ir = 1'b0; shift_ir = 1'b1; tdi = op[i];
      #10;
      chk(ir_so == TDO_PAT[i], "R3/R4 capture bit on ir_so", {8'b0, ir_so}, {8'b0, TDO_PAT[i]});
      chk(ir_active == exp_act, "R5 hold during shift", {4'b0, ir_active}, {4'b0, exp_act});
    end
    @(posedge tck); #2 shift_ir = 1'b0; update_ir = 1'b1;
    #5 chk(ir_active == exp_act, "R5 hold before update edge", {4'b0, ir_active}, {4'b0, exp_act});
    #5;
    exp_act = op;
    chk(ir_active == op, "R2/R5 opcode loaded", {4'b0, ir_active}, {4'b0, op});
    chk({dr_sel, pin_ctl, pin_hiz} == EXP[op], "R8/R9/R10/R11 decode",
        {dr_sel, pin_ctl, pin_hiz}, EXP[op]);
    @(posedge tck); #2 update_ir = 1'b0;
  endtask

  initial begin
    #3 trst_n = 1'b0;
    #1;
    chk(ir_active == 5'b11110, "R1/R6 reset opcode", {4'b0, ir_active}, 9'b11110);
    chk(ir_so == 1'b0, "R1 reset ir_so", {8'b0, ir_so}, 9'b0);
    chk(dr_sel == 7'b0000100, "R1 reset select idcode", {2'b0, dr_sel}, 9'b100);
    exp_act = 5'b11110;
    #20 trst_n = 1'b1;

    // table walk over every opcode
    for (int op = 0; op < 32; op++) load_ir(5'(op));

    // R7: logic reset beats a simultaneous update
    load_ir(5'b00111);
    @(posedge tck); #2 tlr = 1'b1; update_ir = 1'b1;
    #10;
    chk(ir_active == 5'b11110, "R7 tlr to idcode", {4'b0, ir_active}, 9'b11110);
    @(posedge tck); #2 tlr = 1'b0; update_ir = 1'b0;
    exp_act = 5'b11110;

    // R3: capture wins over shift
    @(posedge tck); #2 capture_ir = 1'b1; shift_ir = 1'b1; tdi = 1'b0;
    @(posedge tck); #2 capture_ir = 1'b0; shift_ir = 1'b1;
    #10 chk(ir_so == 1'b1, "R3 capture priority bit0", {8'b0, ir_so}, 9'b1);
    @(posedge tck); #2 shift_ir = 1'b0;
    #10 chk(ir_so == 1'b0, "R3 capture priority bit1", {8'b0, ir_so}, 9'b0);

    // R6: asynchronous test reset between clock edges
    load_ir(5'b01001);
    @(posedge tck); #5 trst_n = 1'b0;
    #1;
    chk(ir_active == 5'b11110, "R6 async trst opcode", {4'b0, ir_active}, 9'b11110);
    chk(dr_sel == 7'b0000100, "R6 async trst select", {2'b0, dr_sel}, 9'b100);
    #20 trst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule